// File: doc/BRIEF.md
# Per-Pin Edge-Qualified Event Filter

This block turns a raw vector of sampled pin levels into per-pin edge events. It holds a snapshot of the pin levels as they stood at the previous evaluation. Each time the evaluate strobe is asserted, every pin's current level is compared with its snapshot bit. The block reports pins that show a qualifying rising or falling transition, and then takes the whole current sample as the new snapshot. Edges are therefore measured between evaluations, not between clock cycles. A pin that toggles and returns to its old level between two strobes produces no event.

Each pin has an enable bit and a trigger selection: rising only, falling only, or both. Both are set through a single-pin configuration port. Events accumulate in a sticky vector until an acknowledge pulse clears them. The pins are split into groups of 32. Each group has a group-enable output, which is high while any pin in the group is enabled. Each group also has a status bit that records whether an evaluation saw any change inside that enabled group. When a disabled pin is enabled, the snapshot of its group is reloaded from the live pins and the status of that group is cleared, so stale differences cannot fire. A configuration write that asks for an unsupported trigger kind, such as a level trigger, is refused and flagged.

Top module: `pin_edge_filter`

## Requirements
- R1: After synchronous reset, the event vector, group enables, group status and reject flag are all 0, every pin is disabled with no edge selected, and the snapshot is all 0.
- R2: An evaluation reports a rising event on a pin when its snapshot bit is 0, its current level is 1, and it is enabled with rising selected.
- R3: An evaluation reports a falling event on a pin when its snapshot bit is 1, its current level is 0, and it is enabled with falling selected. A pin with only rising selected gives no event on a falling transition.
- R4: After every evaluation, the snapshot holds the full current sample, including pins that produced no event. Changing a pin's trigger selection afterwards does not bring back an edge that was already evaluated.
- R5: The reported event vector is the OR of the rising and falling results. With both selected, a pin fires on either direction, and several pins may fire in one evaluation.
- R6: Events stay set until ack_i. A new evaluation ORs its events into those still held. When ack_i and an evaluation occur in the same cycle, only the new events remain.
- R7: The configuration op codes are 3'b000 disable, 3'b001 enable, 3'b100 rising only, 3'b101 falling only and 3'b110 both. The codes 3'b010, 3'b011 and 3'b111 are refused: cfg_reject_o is high for the one cycle after the write, and the pin's configuration is unchanged. An accepted write leaves cfg_reject_o low.
- R8: Enabling a pin that was disabled reloads the snapshot of that pin's 32-pin group from the live pins and clears that group's status bit, in the same cycle that the enable is set. Enabling a pin that is already enabled changes neither the snapshot nor the status.
- R9: Disabling a pin clears only that pin's enable. The group-enable output of a group (bit g covers pins 32g to 32g+31) falls only when no pin in the group is enabled.
- R10: A group status bit is set by an evaluation that finds any pin of an enabled group differing from its snapshot. It is cleared by ack_i.
- R11: Events appear only in the cycle after an evaluate strobe. A pulse on a pin that starts and ends between two evaluations produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PINS | Current sampled pin levels |
| eval_i | input | 1 | Evaluate strobe |
| ack_i | input | 1 | Clears held events and group status |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_pin_i | input | PIN_IDX_W | Pin index of the configuration write |
| cfg_op_i | input | 3 | Configuration op code (see R7) |
| evt_o | output | NUM_PINS | Held per-pin edge events |
| grp_en_o | output | NUM_GROUPS | Per-group enable, high while any pin in the group is enabled |
| grp_stat_o | output | NUM_GROUPS | Per-group change status |
| cfg_reject_o | output | 1 | One-cycle flag for a refused configuration write |

## Verification
The assertions assume that pin levels and strobes are stable around the clock edge, and that a configuration write names a pin index inside the pin range. The bench drives every input on the falling clock edge and uses only in-range pin indices. It runs the scenarios in a fixed order, so the snapshot state at each step is known exactly. It applies evaluate and acknowledge together on purpose, to cover the overlapping case.

// File: rtl/pin_edge_pkg.sv
package pin_edge_pkg;

    localparam int GROUP_W = 32;

    typedef enum logic [2:0] {
        OP_DISABLE   = 3'b000,
        OP_ENABLE    = 3'b001,
        OP_LEVEL_HI  = 3'b010,
        OP_LEVEL_LO  = 3'b011,
        OP_EDGE_RISE = 3'b100,
        OP_EDGE_FALL = 3'b101,
        OP_EDGE_BOTH = 3'b110,
        OP_RESERVED  = 3'b111
    } cfg_op_e;

    typedef struct packed {
        logic valid;
        logic rise;
        logic fall;
    } edge_sel_t;

    function automatic edge_sel_t decode_edge(input logic [2:0] op);
        edge_sel_t s;
        s = '0;
        case (op)
            OP_EDGE_RISE: s = '{valid: 1'b1, rise: 1'b1, fall: 1'b0};
            OP_EDGE_FALL: s = '{valid: 1'b1, rise: 1'b0, fall: 1'b1};
            OP_EDGE_BOTH: s = '{valid: 1'b1, rise: 1'b1, fall: 1'b1};
            default:      s = '0;
        endcase
        return s;
    endfunction

    function automatic logic op_refused(input logic [2:0] op);
        return !(op == OP_DISABLE || op == OP_ENABLE || decode_edge(op).valid);
    endfunction

endpackage

// File: rtl/edge_cfg_bank.sv
module edge_cfg_bank
    import pin_edge_pkg::*;
#(
    parameter int NUM_PINS = 64,
    localparam int PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
    localparam int NUM_GROUPS = (NUM_PINS + GROUP_W - 1) / GROUP_W,
    localparam int PAD_W = NUM_GROUPS * GROUP_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we_i,
    input  logic [PIN_IDX_W-1:0]  cfg_pin_i,
    input  logic [2:0]            cfg_op_i,
    output logic [NUM_PINS-1:0]   en_o,
    output logic [NUM_PINS-1:0]   rise_o,
    output logic [NUM_PINS-1:0]   fall_o,
    output logic [NUM_GROUPS-1:0] grp_en_o,
    output logic [NUM_GROUPS-1:0] refresh_grp_o,
    output logic                  reject_o
);

    logic [NUM_PINS-1:0] en_q, rise_q, fall_q;
    logic                reject_q;
    logic                pin_ok;
    logic                wr_bad;
    edge_sel_t           sel;
    logic [PAD_W-1:0]    en_pad;

    assign pin_ok = ({1'b0, cfg_pin_i} < (PIN_IDX_W+1)'(NUM_PINS));
    assign sel    = decode_edge(cfg_op_i);
    assign wr_bad = cfg_we_i && op_refused(cfg_op_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            rise_q   <= '0;
            fall_q   <= '0;
            reject_q <= 1'b0;
        end else begin
            reject_q <= wr_bad;
            if (cfg_we_i && pin_ok) begin
                if (cfg_op_i == OP_DISABLE) begin
                    en_q[cfg_pin_i] <= 1'b0;
                end else if (cfg_op_i == OP_ENABLE) begin
                    en_q[cfg_pin_i] <= 1'b1;
                end else if (sel.valid) begin
                    rise_q[cfg_pin_i] <= sel.rise;
                    fall_q[cfg_pin_i] <= sel.fall;
                end
            end
        end
    end

    // A disabled pin being enabled asks its group for a snapshot reload.
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            refresh_grp_o[g] = cfg_we_i && pin_ok && (cfg_op_i == OP_ENABLE)
                               && !en_q[cfg_pin_i]
                               && ((int'(cfg_pin_i) / GROUP_W) == g);
        end
    end

    assign en_pad = PAD_W'(en_q);

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp_en
            assign grp_en_o[g] = |en_pad[g*GROUP_W +: GROUP_W];
        end
    endgenerate

    assign en_o     = en_q;
    assign rise_o   = rise_q;
    assign fall_o   = fall_q;
    assign reject_o = reject_q;

    // R7
    reject_cause_chk: assert property (@(posedge clk) disable iff (rst)
        reject_o |-> $past(cfg_we_i && op_refused(cfg_op_i)));

    // R7
    refused_keeps_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        wr_bad |=> ($stable(rise_q) && $stable(fall_q) && $stable(en_q)));

    // R9
    disable_clears_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we_i && pin_ok && cfg_op_i == OP_DISABLE)
        |=> (!en_q[$past(cfg_pin_i)] && $countones(en_q) >= $countones($past(en_q)) - 1));

endmodule

// File: rtl/edge_eval_core.sv
module edge_eval_core
    import pin_edge_pkg::*;
#(
    parameter int NUM_PINS = 64,
    localparam int NUM_GROUPS = (NUM_PINS + GROUP_W - 1) / GROUP_W,
    localparam int PAD_W = NUM_GROUPS * GROUP_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PINS-1:0]   pins_i,
    input  logic                  eval_i,
    input  logic                  ack_i,
    input  logic [NUM_PINS-1:0]   en_i,
    input  logic [NUM_PINS-1:0]   rise_i,
    input  logic [NUM_PINS-1:0]   fall_i,
    input  logic [NUM_GROUPS-1:0] grp_en_i,
    input  logic [NUM_GROUPS-1:0] refresh_grp_i,
    output logic [NUM_PINS-1:0]   evt_o,
    output logic [NUM_GROUPS-1:0] grp_stat_o
);

    logic [NUM_PINS-1:0]   snap_q, evt_q;
    logic [NUM_GROUPS-1:0] stat_q;
    logic [NUM_PINS-1:0]   rise_hit, fall_hit, new_evt, reload_mask;
    logic [PAD_W-1:0]      reload_pad, diff_pad;
    logic [NUM_GROUPS-1:0] grp_changed;

    assign rise_hit = ~snap_q & pins_i & en_i & rise_i;
    assign fall_hit = snap_q & ~pins_i & en_i & fall_i;
    assign new_evt  = eval_i ? (rise_hit | fall_hit) : '0;
    assign diff_pad = PAD_W'(pins_i ^ snap_q);

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
            assign reload_pad[g*GROUP_W +: GROUP_W] = {GROUP_W{refresh_grp_i[g]}};
            assign grp_changed[g] = |diff_pad[g*GROUP_W +: GROUP_W];
        end
    endgenerate

    assign reload_mask = reload_pad[NUM_PINS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            evt_q  <= '0;
            stat_q <= '0;
        end else begin
            if (eval_i) begin
                snap_q <= pins_i;
            end else begin
                snap_q <= (snap_q & ~reload_mask) | (pins_i & reload_mask);
            end
            evt_q <= (ack_i ? '0 : evt_q) | new_evt;
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (refresh_grp_i[g]) begin
                    stat_q[g] <= 1'b0;
                end else begin
                    stat_q[g] <= (stat_q[g] && !ack_i)
                                 || (eval_i && grp_en_i[g] && grp_changed[g]);
                end
            end
        end
    end

    assign evt_o      = evt_q;
    assign grp_stat_o = stat_q;

    // R4
    snapshot_follows_chk: assert property (@(posedge clk) disable iff (rst)
        eval_i |=> (snap_q == $past(pins_i)));

    // R6
    evt_held_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_i |=> (($past(evt_q) & ~evt_q) == '0));

    // R2 R3
    evt_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        eval_i |=> ((evt_q & ~$past(evt_q) & ~$past(en_i)) == '0));

    // R11
    evt_only_on_eval_chk: assert property (@(posedge clk) disable iff (rst)
        !eval_i |=> ((evt_q & ~$past(evt_q)) == '0));

    // R8
    reload_clears_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (refresh_grp_i != '0) |=> ((grp_stat_o & $past(refresh_grp_i)) == '0));

endmodule

// File: rtl/pin_edge_filter.sv
module pin_edge_filter
    import pin_edge_pkg::*;
#(
    parameter int NUM_PINS = 64,
    localparam int PIN_IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
    localparam int NUM_GROUPS = (NUM_PINS + GROUP_W - 1) / GROUP_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PINS-1:0]   pins_i,
    input  logic                  eval_i,
    input  logic                  ack_i,
    input  logic                  cfg_we_i,
    input  logic [PIN_IDX_W-1:0]  cfg_pin_i,
    input  logic [2:0]            cfg_op_i,
    output logic [NUM_PINS-1:0]   evt_o,
    output logic [NUM_GROUPS-1:0] grp_en_o,
    output logic [NUM_GROUPS-1:0] grp_stat_o,
    output logic                  cfg_reject_o
);

    logic [NUM_PINS-1:0]   en_w, rise_w, fall_w;
    logic [NUM_GROUPS-1:0] refresh_w;

    edge_cfg_bank #(.NUM_PINS(NUM_PINS)) i_cfg (
        .clk           (clk),
        .rst           (rst),
        .cfg_we_i      (cfg_we_i),
        .cfg_pin_i     (cfg_pin_i),
        .cfg_op_i      (cfg_op_i),
        .en_o          (en_w),
        .rise_o        (rise_w),
        .fall_o        (fall_w),
        .grp_en_o      (grp_en_o),
        .refresh_grp_o (refresh_w),
        .reject_o      (cfg_reject_o)
    );

    edge_eval_core #(.NUM_PINS(NUM_PINS)) i_eval (
        .clk           (clk),
        .rst           (rst),
        .pins_i        (pins_i),
        .eval_i        (eval_i),
        .ack_i         (ack_i),
        .en_i          (en_w),
        .rise_i        (rise_w),
        .fall_i        (fall_w),
        .grp_en_i      (grp_en_o),
        .refresh_grp_i (refresh_w),
        .evt_o         (evt_o),
        .grp_stat_o    (grp_stat_o)
    );

    // R10
    stat_needs_group_chk: assert property (@(posedge clk) disable iff (rst)
        (eval_i && !ack_i) |=> ((grp_stat_o & ~$past(grp_stat_o) & ~$past(grp_en_o)) == '0));

endmodule

// File: tb/test_pin_edge_filter.sv
module test_pin_edge_filter;
    import pin_edge_pkg::*;

    localparam int  NP = 64;
    localparam int  NG = 2;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pins = '0;
    logic          eval_s = 1'b0;
    logic          ack_s = 1'b0;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_pin = '0;
    logic [2:0]    cfg_op = '0;
    logic [NP-1:0] evt;
    logic [NG-1:0] grp_en, grp_stat;
    logic          reject;

    int checks = 0;
    int fails  = 0;
    logic last_reject;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_edge_filter #(.NUM_PINS(NP)) i_pin_edge_filter (
        .clk(clk), .rst(rst), .pins_i(pins), .eval_i(eval_s), .ack_i(ack_s),
        .cfg_we_i(cfg_we), .cfg_pin_i(cfg_pin), .cfg_op_i(cfg_op),
        .evt_o(evt), .grp_en_o(grp_en), .grp_stat_o(grp_stat), .cfg_reject_o(reject)
    );

    function automatic logic [NP-1:0] b(input int i);
        return NP'(1) << i;
    endfunction

    task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input int pin, input logic [2:0] op);
        @(negedge clk);
        cfg_we = 1'b1; cfg_pin = 6'(pin); cfg_op = op;
        @(negedge clk);
        cfg_we = 1'b0;
        last_reject = reject;
    endtask

    task automatic evaluate(input logic [NP-1:0] p, input logic with_ack);
        @(negedge clk);
        pins = p; eval_s = 1'b1; ack_s = with_ack;
        @(negedge clk);
        eval_s = 1'b0; ack_s = 1'b0;
    endtask

    task automatic set_pins(input logic [NP-1:0] p);
        @(negedge clk);
        pins = p;
    endtask

    task automatic acknowledge();
        @(negedge clk);
        ack_s = 1'b1;
        @(negedge clk);
        ack_s = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 evt", evt, '0);
        chk("R1 grp_en", NP'(grp_en), '0);
        chk("R1 grp_stat", NP'(grp_stat), '0);
        chk("R1 reject", NP'(reject), '0);
    endtask

    task automatic t_rising();
        cfg(3, OP_EDGE_RISE);
        chk("R7 accepted", NP'(last_reject), '0);
        cfg(3, OP_ENABLE);
        chk("R9 grp_en", NP'(grp_en), NP'(2'b01));
        evaluate(b(3), 1'b0);
        chk("R2 rise", evt, b(3));
        chk("R10 stat set", NP'(grp_stat), NP'(2'b01));
        acknowledge();
        chk("R6 ack clears", evt, '0);
        chk("R10 ack clears", NP'(grp_stat), '0);
        evaluate('0, 1'b0);
        chk("R3 rise-only ignores fall", evt, '0);
        acknowledge();
    endtask

    task automatic t_falling_reload();
        set_pins(b(40));
        cfg(40, OP_EDGE_FALL);
        cfg(40, OP_ENABLE);
        chk("R9 grp_en both", NP'(grp_en), NP'(2'b11));
        evaluate('0, 1'b0);
        chk("R3 R8 fall after reload", evt, b(40));
        acknowledge();
    endtask

    task automatic t_both();
        cfg(63, OP_EDGE_BOTH);
        cfg(63, OP_ENABLE);
        evaluate(b(3) | b(63), 1'b0);
        chk("R5 multi rise", evt, b(3) | b(63));
        acknowledge();
        evaluate('0, 1'b0);
        chk("R5 both fall", evt, b(63));
        acknowledge();
    endtask

    task automatic t_sticky();
        evaluate(b(3), 1'b0);
        chk("R6 first", evt, b(3));
        evaluate(b(3) | b(63), 1'b0);
        chk("R6 accumulate", evt, b(3) | b(63));
        evaluate(b(3), 1'b1);
        chk("R6 ack with eval", evt, b(63));
        acknowledge();
    endtask

    task automatic t_snapshot();
        cfg(10, OP_EDGE_FALL);
        cfg(10, OP_ENABLE);
        evaluate(b(3) | b(10), 1'b0);
        chk("R4 fall-only no rise", evt, '0);
        cfg(10, OP_EDGE_RISE);
        evaluate(b(3) | b(10), 1'b0);
        chk("R4 snapshot updated", evt, '0);
        set_pins(b(3));
        set_pins(b(3) | b(10));
        evaluate(b(3) | b(10), 1'b0);
        chk("R11 pulse between evals", evt, '0);
    endtask

    task automatic t_reject();
        cfg(10, OP_LEVEL_HI);
        chk("R7 reject level", NP'(last_reject), NP'(1));
        @(negedge clk);
        chk("R7 one cycle", NP'(reject), '0);
        cfg(10, OP_RESERVED);
        chk("R7 reject reserved", NP'(last_reject), NP'(1));
        evaluate(b(3), 1'b0);
        chk("R7 cfg unchanged fall", evt, '0);
        evaluate(b(3) | b(10), 1'b0);
        chk("R7 cfg unchanged rise", evt, b(10));
        acknowledge();
    endtask

    task automatic t_mask();
        cfg(40, OP_DISABLE);
        chk("R9 group stays", NP'(grp_en), NP'(2'b11));
        cfg(63, OP_DISABLE);
        chk("R9 group drops", NP'(grp_en), NP'(2'b01));
        evaluate(b(3) | b(10) | b(40) | b(63), 1'b0);
        chk("R9 masked no evt", evt, '0);
        cfg(3, OP_DISABLE);
        chk("R9 group0 stays", NP'(grp_en), NP'(2'b01));
        evaluate(b(40) | b(63), 1'b0);
        chk("R9 falls ignored", evt, '0);
        evaluate(b(10) | b(40) | b(63), 1'b0);
        chk("R9 neighbour live", evt, b(10));
        acknowledge();
        cfg(10, OP_DISABLE);
        chk("R9 all off", NP'(grp_en), '0);
    endtask

    task automatic t_unmask_rules();
        cfg(10, OP_ENABLE);
        evaluate(b(40) | b(63), 1'b0);
        chk("R8 quiet", evt, '0);
        set_pins(b(10) | b(40) | b(63));
        cfg(10, OP_ENABLE);
        evaluate(b(10) | b(40) | b(63), 1'b0);
        chk("R8 enabled pin no reload", evt, b(10));
        chk("R10 stat after edge", NP'(grp_stat), NP'(2'b01));
        cfg(3, OP_ENABLE);
        chk("R8 reload clears stat", NP'(grp_stat), '0);
        chk("R8 events kept", evt, b(10));
        chk("R9 group0 on", NP'(grp_en), NP'(2'b01));
    endtask

    initial begin
        last_reject = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rising();
        t_falling_reload();
        t_both();
        t_sticky();
        t_snapshot();
        t_reject();
        t_mask();
        t_unmask_rules();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule